// File: doc/BRIEF.md
# Pulsed Two-Source Error Interrupt Unit

This block collects two error events from an instruction cache, the write-hit event (a store into the cached address range) and the write-error event (a failed write to the cache's remote data store). It keeps a sticky raw flag for each event and a per-source enable, and drives a one-cycle interrupt pulse. The raw flags also go back to the cache on a dedicated port, so the cache can logically disable itself while either flag is set.

Software works through four 32-bit registers on a simple write/read register bus. The raw register lets software set a flag for diagnostics. The masked view shows pending, enabled sources. Writing the masked view clears flags and acts as end-of-interrupt: if an enabled source is still pending after that write, the block emits a fresh pulse. Two mirrored registers manage the enables. One of them only turns bits on and the other only turns bits off, and both read back the same enable value.

Top module: `pirq_unit`

## Requirements
- R1: After a synchronous active-low reset, both raw flags and both enables are 0, `irq_pulse` is low, and every register reads 0.
- R2: At offset 0x80 (raw), a write with data bit 1 sets the write-hit flag and a write with data bit 0 sets the write-error flag. A 0 in either bit leaves the flag unchanged. The register reads back the flags in bits 1 and 0.
- R3: At offset 0x84 (masked), a write with a 1 in bit 1 or bit 0 clears the matching raw flag whether or not that source is enabled. A 0 leaves the flag unchanged.
- R4: Offset 0x84 reads the raw flags ANDed bitwise with the enables.
- R5: At offset 0x88 (enable-set), a 1 written to bit 1 or bit 0 enables that source. Afterwards both 0x88 and 0x8C read 1 in that bit.
- R6: At offset 0x8C (enable-clear), a 1 written to bit 1 or bit 0 disables that source, and both registers then read 0 in that bit. A 0 written to either enable register changes nothing.
- R7: Read bits 31:2 of every register are 0, and offsets other than the four above read 0. Write data bits 31:2 have no effect.
- R8: A high `evt_wr_hit` strobe sets raw bit 1 and a high `evt_wr_err` strobe sets raw bit 0 at the next clock edge. `raw_status` always equals the raw flags.
- R9: If an event strobe and a masked-register clear of the same bit fall in the same cycle, the flag stays set.
- R10: When the OR of the masked bits goes from 0 to 1, `irq_pulse` is high for exactly the cycle after the clock edge that made the change. This includes enabling a source that is already pending.
- R11: Any write to offset 0x84 is an end-of-interrupt. In the cycle after that write, `irq_pulse` is high exactly when some masked bit is still set.
- R12: While the masked OR stays high and no end-of-interrupt write occurs, `irq_pulse` stays low after its single pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe, one per write |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| evt_wr_hit | input | 1 | Cache strobe: write into the cached range |
| evt_wr_err | input | 1 | Cache strobe: write error on the remote data store |
| raw_status | output | 2 | Raw flags to the cache (bit 1 write-hit, bit 0 write-error) |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that `bus_wr_en` is a single-cycle strobe with a stable offset and data, and that event strobes may come in any cycle, including a cycle that writes the same bit. The stimulus drives each write for exactly one cycle and returns the strobes low before the next one. It sweeps every raw value, every enable value and every two-bit write value against each of the four registers. It repeats that sweep with event strobes arriving alone and arriving together with a masked-register clear. High write-data bits are always set, so that ignoring the reserved bits is exercised on every write.

// File: rtl/pirq_pkg.sv
// Shared constants and types for the pulsed interrupt unit.
// Assumes a fixed set of two sources; bit positions are software-visible.
package pirq_pkg;

    localparam int unsigned PIRQ_NUM_SRC = 2;
    localparam int unsigned PIRQ_SRC_ERR = 0;   // write-error flag position
    localparam int unsigned PIRQ_SRC_HIT = 1;   // write-hit flag position

    typedef enum logic [1:0] {
        SEL_RAW    = 2'd0,
        SEL_MASKED = 2'd1,
        SEL_EN_SET = 2'd2,
        SEL_EN_CLR = 2'd3
    } pirq_sel_e;

    typedef struct packed {
        logic      hit;
        pirq_sel_e sel;
    } pirq_dec_t;

endpackage

// File: rtl/pirq_reg_decode.sv
// Register offset decoder.
// Compares the full byte offset against the four register offsets; any
// other value (including unaligned ones) reports no hit.
module pirq_reg_decode
    import pirq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned OFF_RAW    = 'h80,
    parameter int unsigned OFF_MASKED = 'h84,
    parameter int unsigned OFF_EN_SET = 'h88,
    parameter int unsigned OFF_EN_CLR = 'h8C
) (
    input  logic [ADDR_W-1:0] addr,
    output pirq_dec_t         dec
);

    localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFF_RAW);
    localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFF_MASKED);
    localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(OFF_EN_SET);
    localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFF_EN_CLR);

    // Map an offset to a register select plus a hit flag.
    always_comb begin
        dec.hit = 1'b1;
        dec.sel = SEL_RAW;
        if (addr == A_RAW) begin
            dec.sel = SEL_RAW;
        end else if (addr == A_MASKED) begin
            dec.sel = SEL_MASKED;
        end else if (addr == A_EN_SET) begin
            dec.sel = SEL_EN_SET;
        end else if (addr == A_EN_CLR) begin
            dec.sel = SEL_EN_CLR;
        end else begin
            dec.hit = 1'b0;
        end
    end

endmodule

// File: rtl/pirq_src_slice.sv
// State for one interrupt source: a sticky raw flag and an enable bit.
// Assumes raw_set and raw_clr never come in the same cycle, and neither
// do en_set and en_clr (each pair comes from different offsets).
// A hardware event outranks a software clear.
module pirq_src_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic raw_set,
    input  logic raw_clr,
    input  logic en_set,
    input  logic en_clr,
    output logic raw_q,
    output logic en_q
);

    // Raw flag: an event or a diagnostic set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (evt || raw_set) begin
            raw_q <= 1'b1;
        end else if (raw_clr) begin
            raw_q <= 1'b0;
        end
    end

    // Enable bit: a set and a clear come from different offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_set) begin
            en_q <= 1'b1;
        end else if (en_clr) begin
            en_q <= 1'b0;
        end
    end

    AST_EVT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> raw_q);                                             // R8
    AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && raw_clr) |=> raw_q);                                // R9
    AST_CLR_DROPS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_clr && !evt) |=> !raw_q);                              // R3
    AST_DIAG_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        raw_set |=> raw_q);                                         // R2
    AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !raw_set && !raw_clr) |=> $stable(raw_q));         // R2
    AST_EN_SET_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        en_set |=> en_q);                                           // R5
    AST_EN_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !en_q);                                          // R6
    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_set && !en_clr) |=> $stable(en_q));                    // R6

endmodule

// File: rtl/pirq_pulse_gen.sv
// Interrupt pulse generator.
// Emits a one-cycle pulse when the OR of the masked bits rises, or in the
// cycle after an end-of-interrupt write if anything is still pending.
// The output is a function of registered state only, so it is glitch-free
// with respect to the bus inputs.
module pirq_pulse_gen #(
    parameter int unsigned NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] masked,
    input  logic               eoi,
    output logic               irq_pulse
);

    logic any_now;
    logic any_q;
    logic eoi_q;

    // Reduce the masked bits to one pending indication.
    always_comb any_now = |masked;

    // Remember the last pending value and whether an end-of-interrupt arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_q <= 1'b0;
            eoi_q <= 1'b0;
        end else begin
            any_q <= any_now;
            eoi_q <= eoi;
        end
    end

    // Pulse on a new pending condition or on a re-arm after end-of-interrupt.
    always_comb irq_pulse = any_now && (!any_q || eoi_q);

    AST_PULSE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (|masked));                                   // R10
    AST_RISE_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|masked) |-> irq_pulse);                              // R10
    AST_EOI_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        eoi |=> (irq_pulse == (|masked)));                          // R11
    AST_NO_REPEAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && !eoi) |=> !irq_pulse);                        // R12

endmodule

// File: rtl/pirq_unit.sv
// Pulsed two-source error interrupt unit (top).
// Holds raw flags and enables for the write-hit and write-error sources,
// serves four 32-bit registers on a simple register bus, and drives a
// one-cycle interrupt pulse. Assumes bus_wr_en is one cycle per write and
// reads are combinational from bus_addr.
module pirq_unit
    import pirq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned OFF_RAW    = 'h80,
    parameter int unsigned OFF_MASKED = 'h84,
    parameter int unsigned OFF_EN_SET = 'h88,
    parameter int unsigned OFF_EN_CLR = 'h8C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_wr_hit,
    input  logic              evt_wr_err,
    output logic [1:0]        raw_status,
    output logic              irq_pulse
);

    localparam int unsigned NSRC = PIRQ_NUM_SRC;

    pirq_dec_t         dec;
    logic [NSRC-1:0]   evt_vec;
    logic [NSRC-1:0]   raw_vec;
    logic [NSRC-1:0]   en_vec;
    logic [NSRC-1:0]   masked_vec;
    logic              wr_raw;
    logic              wr_masked;
    logic              wr_en_set;
    logic              wr_en_clr;

    pirq_reg_decode #(
        .ADDR_W     (ADDR_W),
        .OFF_RAW    (OFF_RAW),
        .OFF_MASKED (OFF_MASKED),
        .OFF_EN_SET (OFF_EN_SET),
        .OFF_EN_CLR (OFF_EN_CLR)
    ) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    // Qualify the write strobe per register.
    always_comb begin
        wr_raw    = bus_wr_en && dec.hit && (dec.sel == SEL_RAW);
        wr_masked = bus_wr_en && dec.hit && (dec.sel == SEL_MASKED);
        wr_en_set = bus_wr_en && dec.hit && (dec.sel == SEL_EN_SET);
        wr_en_clr = bus_wr_en && dec.hit && (dec.sel == SEL_EN_CLR);
    end

    // Place the event strobes at their flag positions.
    always_comb begin
        evt_vec               = '0;
        evt_vec[PIRQ_SRC_HIT] = evt_wr_hit;
        evt_vec[PIRQ_SRC_ERR] = evt_wr_err;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        pirq_src_slice u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_vec[i]),
            .raw_set (wr_raw    && bus_wdata[i]),
            .raw_clr (wr_masked && bus_wdata[i]),
            .en_set  (wr_en_set && bus_wdata[i]),
            .en_clr  (wr_en_clr && bus_wdata[i]),
            .raw_q   (raw_vec[i]),
            .en_q    (en_vec[i])
        );
    end

    // Masked view: pending sources that are enabled.
    always_comb masked_vec = raw_vec & en_vec;

    // Raw flags go straight to the cache for disable gating.
    always_comb raw_status = raw_vec;

    // Read mux; reserved bits and unknown offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (dec.hit) begin
            unique case (dec.sel)
                SEL_RAW:    bus_rdata[NSRC-1:0] = raw_vec;
                SEL_MASKED: bus_rdata[NSRC-1:0] = masked_vec;
                SEL_EN_SET,
                SEL_EN_CLR: bus_rdata[NSRC-1:0] = en_vec;
                default:    bus_rdata = '0;
            endcase
        end
    end

    pirq_pulse_gen #(
        .NUM_SRC (NSRC)
    ) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .masked    (masked_vec),
        .eoi       (wr_masked),
        .irq_pulse (irq_pulse)
    );

    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NSRC] == '0);                            // R7
    AST_RAW_PORT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.hit && dec.sel == SEL_RAW) |-> (bus_rdata[1:0] == raw_status)); // R8

endmodule

// File: tb/tb_pirq_unit.sv
// Self-checking bench: sweeps raw, enable and write values over every
// register, with and without coincident event strobes.
module tb_pirq_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr_en;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        evt_wr_hit;
    logic        evt_wr_err;
    logic [1:0]  raw_status;
    logic        irq_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [1:0] m_raw;
    logic [1:0] m_en;

    always #2 clk = ~clk;

    pirq_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr_en  (bus_wr_en),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .evt_wr_hit (evt_wr_hit),
        .evt_wr_err (evt_wr_err),
        .raw_status (raw_status),
        .irq_pulse  (irq_pulse)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock cycle of stimulus; the model is updated and the pulse checked.
    task automatic do_cycle(bit wr, logic [7:0] a, logic [1:0] d, bit hit, bit err, string req);
        logic [1:0] pend_before;
        bit         eoi;
        bit         exp_p;
        pend_before = m_raw & m_en;
        eoi = 1'b0;
        @(negedge clk);
        bus_wr_en  = wr;
        bus_addr   = a;
        bus_wdata  = {30'h3FFF_FFFF, d};   // reserved bits always high (R7)
        evt_wr_hit = hit;
        evt_wr_err = err;
        if (wr) begin
            case (a)
                8'h80: m_raw = m_raw | d;
                8'h84: begin m_raw = m_raw & ~d; eoi = 1'b1; end
                8'h88: m_en  = m_en | d;
                8'h8C: m_en  = m_en & ~d;
                default: ;
            endcase
        end
        m_raw = m_raw | {hit, err};
        exp_p = (|(m_raw & m_en)) && (!(|pend_before) || eoi);
        @(negedge clk);
        bus_wr_en  = 1'b0;
        evt_wr_hit = 1'b0;
        evt_wr_err = 1'b0;
        chk(req, "irq_pulse", {31'b0, irq_pulse}, {31'b0, exp_p});
    endtask

    task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, $sformatf("rdata@%h", a), bus_rdata, exp);
    endtask

    // Read back every register and the raw port; no pulse may repeat.
    task automatic check_regs(string req);
        @(negedge clk);
        chk("R12", "irq_pulse idle", {31'b0, irq_pulse}, 32'h0);
        chk("R8", "raw_status", {30'b0, raw_status}, {30'b0, m_raw});
        rd("R2", 8'h80, {30'b0, m_raw});
        rd("R4", 8'h84, {30'b0, m_raw & m_en});
        rd("R5", 8'h88, {30'b0, m_en});
        rd("R6", 8'h8C, {30'b0, m_en});
        rd("R7", 8'h90, 32'h0);
        rd(req,  8'h81, 32'h0);
    endtask

    task automatic wipe();
        do_cycle(1'b1, 8'h84, 2'b11, 1'b0, 1'b0, "R3");
        do_cycle(1'b1, 8'h8C, 2'b11, 1'b0, 1'b0, "R6");
    endtask

    initial begin
        rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = 8'h80; bus_wdata = '0;
        evt_wr_hit = 1'b0; evt_wr_err = 1'b0;
        m_raw = 2'b00; m_en = 2'b00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "irq_pulse reset", {31'b0, irq_pulse}, 32'h0);
        rd("R1", 8'h80, 32'h0);
        rd("R1", 8'h84, 32'h0);
        rd("R1", 8'h88, 32'h0);
        rd("R1", 8'h8C, 32'h0);
        chk("R1", "raw_status reset", {30'b0, raw_status}, 32'h0);

        // Register sweep: every raw x enable x value x register (R2..R6, R10, R11).
        for (int r = 0; r < 4; r++)
            for (int e = 0; e < 4; e++)
                for (int w = 0; w < 4; w++)
                    for (int op = 0; op < 4; op++) begin
                        logic [7:0] a;
                        string      tag;
                        wipe();
                        do_cycle(1'b1, 8'h80, 2'(r), 1'b0, 1'b0, "R2");
                        do_cycle(1'b1, 8'h88, 2'(e), 1'b0, 1'b0, "R10");
                        case (op)
                            0: begin a = 8'h80; tag = "R2";  end
                            1: begin a = 8'h84; tag = "R11"; end
                            2: begin a = 8'h88; tag = "R5";  end
                            default: begin a = 8'h8C; tag = "R6"; end
                        endcase
                        do_cycle(1'b1, a, 2'(w), 1'b0, 1'b0, tag);
                        check_regs(tag);
                    end

        // Event sweep: strobes alone, and together with a masked clear (R8, R9).
        for (int r = 0; r < 4; r++)
            for (int e = 0; e < 4; e++)
                for (int ev = 0; ev < 4; ev++)
                    for (int w = 0; w < 5; w++) begin
                        logic [1:0] evb;
                        evb = 2'(ev);
                        wipe();
                        do_cycle(1'b1, 8'h88, 2'(e), 1'b0, 1'b0, "R10");
                        do_cycle(1'b1, 8'h80, 2'(r), 1'b0, 1'b0, "R10");
                        if (w == 4)
                            do_cycle(1'b0, 8'h80, 2'b00, evb[1], evb[0], "R8");
                        else
                            do_cycle(1'b1, 8'h84, 2'(w), evb[1], evb[0], "R9");
                        check_regs("R9");
                    end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule